// File: doc/BRIEF.md
# Carry-Select Adder, 8-bit

This block adds two 8-bit unsigned operands and a carry-in in one combinational pass, and returns an 8-bit sum and a carry-out. The operands are split into a lower nibble and an upper nibble. A single ripple block adds the lower nibbles with the external carry-in and produces the lower sum bits and the carry out of bit 3.

The upper nibble is built twice. One copy assumes that no carry arrives from below and the other assumes that one does. Both copies work at the same time as the lower block, so their results are ready while the lower carry is still settling. That lower carry then drives a row of 2:1 multiplexers: four choose the upper sum bits and a fifth chooses the final carry-out. The result is complete one multiplexer delay after the lower carry settles, instead of a full second ripple chain later.

The block is meant to sit in a datapath where the critical path runs through the adder. It has no state and no clock.

Top module: `csel_adder8`

## Requirements
- R1: For every pair of operands and every carry-in, the 9-bit value {cy_out, sum_out} equals opa + opb + cy_in.
- R2: sum_out[3:0] equals bits 3..0 of opa[3:0] + opb[3:0] + cy_in.
- R3: When opa[3:0] + opb[3:0] + cy_in is 16 or more, sum_out[7:4] equals (opa[7:4] + opb[7:4] + 1) mod 16. Otherwise it equals (opa[7:4] + opb[7:4]) mod 16.
- R4: cy_out is the carry out of the upper nibble, taken under the same lower-carry condition as R3.
- R5: The upper operand bits opa[7:4] and opb[7:4] have no effect on sum_out[3:0].
- R6: The longest carry chain gives the correct result: 0xFF + 0x00 + 1 gives sum_out = 0x00 and cy_out = 1, and 0x0F + 0x00 + 1 gives sum_out = 0x10 and cy_out = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 8 | First operand, unsigned |
| opb | input | 8 | Second operand, unsigned |
| cy_in | input | 1 | Carry into bit 0 |
| sum_out | output | 8 | Sum bits |
| cy_out | output | 1 | Carry out of bit 7 |

## Verification
The assertions are immediate checks on settled combinational values. They assume that the operand and carry inputs are stable, two-valued bits that hold their value long enough for every internal carry to resolve. For the same reason, the upper candidate with the assumed carry of 1 must differ from the other candidate by exactly one unit.

The bench meets these assumptions by changing inputs only on the falling clock edge and comparing results on the next rising edge. It never drives X or Z. The stimulus covers every operand pair with both carry-in values. It then adds directed cases that force the lower carry to toggle while the upper nibbles stay fixed, and the full-length carry chain.

// File: rtl/csel_pkg.sv
`timescale 1ns/1ps
package csel_pkg;

    // Operand geometry
    localparam int FULL_W = 8;
    localparam int LOW_W  = 4;
    localparam int HIGH_W = FULL_W - LOW_W;

    // One upper-nibble candidate: its sum bits and its carry out
    typedef struct packed {
        logic              carry;
        logic [HIGH_W-1:0] sum;
    } lane_t;

    // Which assumed carry a candidate was built for
    typedef enum logic {
        ASSUME_NO_CARRY = 1'b0,
        ASSUME_CARRY    = 1'b1
    } assume_e;

    // Carry generate for one bit position
    function automatic logic bit_gen(input logic a, input logic b);
        return a & b;
    endfunction

    // Carry propagate for one bit position
    function automatic logic bit_prop(input logic a, input logic b);
        return a ^ b;
    endfunction

endpackage

// File: rtl/csel_bit.sv
`timescale 1ns/1ps
module csel_bit
    import csel_pkg::*;
(
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic co
);

    logic gen_w;
    logic prop_w;

    always_comb begin
        gen_w  = bit_gen(a, b);
        prop_w = bit_prop(a, b);
        s      = prop_w ^ ci;
        co     = gen_w | (prop_w & ci);
    end

endmodule

// File: rtl/csel_ripple.sv
`timescale 1ns/1ps
module csel_ripple #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         co
);

    localparam int CW = W + 1;

    logic [W:0] chain;

    assign chain[0] = ci;

    for (genvar i = 0; i < W; i++) begin : g_bit
        csel_bit u_bit (
            .a  (a[i]),
            .b  (b[i]),
            .ci (chain[i]),
            .s  (s[i]),
            .co (chain[i+1])
        );
    end

    assign co = chain[W];

    // The chain of single-bit cells must give the same result as arithmetic addition
    always_comb begin
        p_blk_sum_r1: assert ({co, s} == ({1'b0, a} + {1'b0, b} + CW'(ci)))
            else $error("p_blk_sum_r1 ripple block mismatch");
    end

endmodule

// File: rtl/csel_pick.sv
`timescale 1ns/1ps
module csel_pick
    import csel_pkg::*;
(
    input  logic  sel,
    input  lane_t cand0,
    input  lane_t cand1,
    output lane_t res
);

    localparam int MW = HIGH_W + 1;

    logic [MW-1:0] in0;
    logic [MW-1:0] in1;
    logic [MW-1:0] outv;

    assign in0 = cand0;
    assign in1 = cand1;

    // One 2:1 multiplexer per upper sum bit plus one for the carry
    for (genvar i = 0; i < MW; i++) begin : g_mux
        assign outv[i] = sel ? in1[i] : in0[i];
    end

    assign res = outv;

    // The carry-1 candidate must be the carry-0 candidate plus one unit
    always_comb begin
        p_cand_step_r3: assert (in1 == in0 + MW'(1))
            else $error("p_cand_step_r3 candidate step mismatch");
        p_cand_carry_r4: assert (!cand0.carry || cand1.carry)
            else $error("p_cand_carry_r4 candidate carry ordering");
    end

endmodule

// File: rtl/csel_adder8.sv
`timescale 1ns/1ps
module csel_adder8
    import csel_pkg::*;
(
    input  logic [FULL_W-1:0] opa,
    input  logic [FULL_W-1:0] opb,
    input  logic              cy_in,
    output logic [FULL_W-1:0] sum_out,
    output logic              cy_out
);

    localparam int LCW = LOW_W + 1;
    localparam int TCW = FULL_W + 1;

    logic [LOW_W-1:0] low_sum;
    logic             low_carry;
    lane_t            cand [2];
    lane_t            chosen;

    csel_ripple #(.W(LOW_W)) u_low (
        .a  (opa[LOW_W-1:0]),
        .b  (opb[LOW_W-1:0]),
        .ci (cy_in),
        .s  (low_sum),
        .co (low_carry)
    );

    // Two upper copies, one for each assumed carry
    for (genvar k = 0; k < 2; k++) begin : g_upper
        localparam assume_e ASM = assume_e'(k);
        csel_ripple #(.W(HIGH_W)) u_up (
            .a  (opa[FULL_W-1:LOW_W]),
            .b  (opb[FULL_W-1:LOW_W]),
            .ci (logic'(ASM)),
            .s  (cand[k].sum),
            .co (cand[k].carry)
        );
    end

    csel_pick u_pick (
        .sel   (low_carry),
        .cand0 (cand[ASSUME_NO_CARRY]),
        .cand1 (cand[ASSUME_CARRY]),
        .res   (chosen)
    );

    assign sum_out = {chosen.sum, low_sum};
    assign cy_out  = chosen.carry;

    always_comb begin
        p_total_r1: assert ({cy_out, sum_out} == ({1'b0, opa} + {1'b0, opb} + TCW'(cy_in)))
            else $error("p_total_r1 full sum mismatch");
        p_low_r2: assert ({low_carry, sum_out[LOW_W-1:0]} ==
                          ({1'b0, opa[LOW_W-1:0]} + {1'b0, opb[LOW_W-1:0]} + LCW'(cy_in)))
            else $error("p_low_r2 lower nibble mismatch");
    end

endmodule

// File: tb/test_csel_adder8.sv
`timescale 1ns/1ps
module test_csel_adder8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] opa = '0;
    logic [7:0] opb = '0;
    logic       cy_in = 1'b0;
    logic [7:0] sum_out;
    logic       cy_out;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [8:0] exp;
        logic [8:0] mask;
        string      tag;
    } item_t;

    item_t sb[$];

    always #4 clk = ~clk;   // 125 MHz

    csel_adder8 i_csel_adder8 (
        .opa     (opa),
        .opb     (opb),
        .cy_in   (cy_in),
        .sum_out (sum_out),
        .cy_out  (cy_out)
    );

    // Monitor: compare one result on each rising edge
    always @(posedge clk) begin
        if (!rst && sb.size() > 0) begin
            item_t it;
            logic [8:0] got;
            it  = sb.pop_front();
            got = {cy_out, sum_out};
            checks++;
            if ((got & it.mask) !== (it.exp & it.mask)) begin
                failures++;
                $display("FAIL %s a=%h b=%h ci=%b got=%h exp=%h mask=%h",
                         it.tag, opa, opb, cy_in, got & it.mask, it.exp & it.mask, it.mask);
            end
        end
    end

    // Driver: drive on the falling edge, push expected value
    task automatic drive(input logic [7:0] a, input logic [7:0] b, input logic c,
                         input logic [8:0] mask, input string tag);
        item_t it;
        int lo;
        int hi;
        @(negedge clk);
        opa   = a;
        opb   = b;
        cy_in = c;
        lo = int'(a[3:0]) + int'(b[3:0]) + int'(c);
        hi = int'(a[7:4]) + int'(b[7:4]) + ((lo >= 16) ? 1 : 0);
        it.exp  = 9'(hi * 16 + (lo % 16));
        it.mask = mask;
        it.tag  = tag;
        sb.push_back(it);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired at cycle %0d", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // Quiescent state with zero inputs
        drive(8'h00, 8'h00, 1'b0, 9'h1FF, "R1 zero");

        // R6 longest carry chains
        drive(8'hFF, 8'h00, 1'b1, 9'h1FF, "R6 full chain");
        drive(8'h0F, 8'h00, 1'b1, 9'h1FF, "R6 low chain only");
        drive(8'hFF, 8'h01, 1'b0, 9'h1FF, "R6 b side chain");

        // R3/R4 lower carry toggles while upper nibbles stay fixed
        drive(8'hF8, 8'h07, 1'b0, 9'h1F0, "R3 no low carry");
        drive(8'hF8, 8'h07, 1'b1, 9'h1F0, "R3 low carry");
        drive(8'hF8, 8'h07, 1'b0, 9'h100, "R4 cout no low carry");
        drive(8'hF8, 8'h07, 1'b1, 9'h100, "R4 cout via low carry");
        drive(8'h8F, 8'h71, 1'b0, 9'h1F0, "R3 upper wrap");
        drive(8'h90, 8'h70, 1'b0, 9'h100, "R4 cout upper only");

        // R5 upper bits varied, lower nibble fixed
        for (int u = 0; u < 16; u++) begin
            drive({4'(u), 4'h9}, {4'(15 - u), 4'h6}, 1'b1, 9'h00F, "R5 upper ignored");
        end
        drive(8'h35, 8'hC2, 1'b0, 9'h00F, "R2 low nibble");

        // R1 exhaustive sweep
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                drive(8'(a), 8'(b), 1'((a + b) & 1), 9'h1FF, "R1 sweep");
                drive(8'(a), 8'(b), 1'(~(a + b) & 1), 9'h1FF, "R1 sweep");
            end
        end

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule